// File: doc/BRIEF.md
# Duty-Cycle Dithering Quantizer

This block sits between a control law that produces a wide duty command and a PWM counter that only accepts a narrower duty code. Once per switching period, marked by a strobe, it picks one of the two codes that bracket the wide command: the floor of its integer part or the next code up. The fractional bits decide how often the upper code is used, so that over many periods the average code tracks the full-precision command.

Three methods make that choice. The first is a short fixed cycle driven by the top fractional bits. The second compares the fraction with a free-running pseudo-random sequence. The third is a first-order error-feedback loop that carries the leftover fraction into later periods and so pushes the quantization noise toward high frequencies. The integer part is the upper `OUT_W` bits of the command and the fraction is the remaining low bits. The chosen code is registered and presented together with a one-cycle valid pulse.

Top module: `dither_quantizer`

## Requirements
- R1: After every strobe, `duty_o` equals either the integer part of the command sampled at that strobe or that integer part plus one.
- R2: A command whose fractional bits are all zero yields exactly its integer part in every mode.
- R3: When the integer part is all ones, the upper choice stays at all ones, so the output never wraps to zero.
- R4: `duty_o` changes only in the cycle after a clock edge at which `period_i` is high. `valid_o` is high for exactly that one cycle and is low otherwise.
- R5: Mode code 0 selects the fixed-cycle method. k is the top two fractional bits and p is a 2-bit phase that goes 0,1,2,3 and wraps, advancing at every strobe in every mode. The upper code is chosen when p+k is at least 4, so k=1 gives three lower periods followed by one upper period.
- R6: Mode code 1 selects the pseudo-random method, using a 16-bit right-shifting Galois LFSR with feedback mask 0xB400. At each strobe it shifts right one place and XORs in the mask when the bit shifted out was 1. The upper code is chosen when the fraction is strictly greater than the upper 8 bits of the LFSR value held before that strobe's advance. The LFSR advances at every strobe in every mode.
- R7: Mode codes 2 and 3 select the error-feedback method. At each strobe the fraction is added to an 8-bit accumulator. A carry out of the sum selects the upper code, and the low 8 bits of the sum are kept. The accumulator advances at every strobe in every mode.
- R8: In error-feedback mode, with a constant fraction f held for 256 consecutive strobes after the accumulator has been cleared, the upper code is chosen exactly f times.
- R9: At a strobe whose mode code differs from the code seen at the previous strobe, the accumulator and the phase are taken as zero for that strobe's decision and update. The LFSR is not affected.
- R10: Synchronous reset sets `duty_o` to 0, `valid_o` to 0, the accumulator and the phase to 0, the LFSR to 0xACE1, and the remembered mode to code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | CMD_W | Wide duty command: integer part in the upper bits, fraction in the lower bits |
| mode_i | input | 2 | Method select: 0 fixed cycle, 1 pseudo-random, 2 or 3 error feedback |
| period_i | input | 1 | One-cycle strobe at each switching-period boundary |
| duty_o | output | OUT_W | Quantized duty code for the PWM counter |
| valid_o | output | 1 | One-cycle pulse marking a freshly updated `duty_o` |

## Verification
The hardest condition to reach is a mode switch that lands while the accumulator and the phase hold non-zero leftovers, because a missing clear only shows up when those leftovers would have changed a later decision. The stimulus first runs error feedback long enough to leave a known residue in the accumulator. It then switches briefly to the fixed cycle, so both counters keep advancing, and returns to error feedback with a fraction chosen so that an uncleared accumulator would carry where a cleared one does not. A reference model run from the stated rules covers the pseudo-random sequence, which cannot be seen directly and is only checked through its effect on the output.

// File: rtl/dq_pkg.sv
package dq_pkg;

    typedef enum logic [1:0] {
        DQ_PATTERN = 2'd0,
        DQ_RANDOM  = 2'd1,
        DQ_SIGMA   = 2'd2,
        DQ_SIGMA_B = 2'd3
    } dq_mode_e;

    // one upper-level vote per method
    typedef struct packed {
        logic pat;
        logic rnd;
        logic sd;
    } dq_votes_t;

    function automatic logic dq_pick(input dq_mode_e m, input dq_votes_t v);
        logic r;
        unique case (m)
            DQ_PATTERN: r = v.pat;
            DQ_RANDOM:  r = v.rnd;
            default:    r = v.sd;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dq_pattern_seq.sv
module dq_pattern_seq #(
    parameter int PH_W = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            step_i,
    input  logic            clear_i,
    input  logic [PH_W-1:0] k_i,
    output logic            up_o
);
    logic [PH_W-1:0] phase_q;
    logic [PH_W-1:0] phase_eff;
    logic [PH_W:0]   sum;

    assign phase_eff = clear_i ? '0 : phase_q;
    assign sum       = {1'b0, phase_eff} + {1'b0, k_i};
    assign up_o      = sum[PH_W];

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= '0;
        else if (step_i)
            phase_q <= phase_eff + PH_W'(1);
    end
endmodule

// File: rtl/dq_lfsr.sv
module dq_lfsr #(
    parameter int           W     = 16,
    parameter int           CMP_W = 8,
    parameter logic [W-1:0] TAPS  = 16'hB400,
    parameter logic [W-1:0] SEED  = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_i,
    input  logic [CMP_W-1:0] frac_i,
    output logic             up_o
);
    logic [W-1:0]     state_q;
    logic [W-1:0]     state_nxt;
    logic [CMP_W-1:0] window;

    assign state_nxt = state_q[0] ? ((state_q >> 1) ^ TAPS) : (state_q >> 1);

    generate
        if (W >= CMP_W) begin : g_top_bits
            assign window = state_q[W-1 -: CMP_W];
        end else begin : g_widen
            assign window = {state_q, {(CMP_W-W){1'b0}}};
        end
    endgenerate

    assign up_o = frac_i > window;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= SEED;
        else if (step_i)
            state_q <= state_nxt;
    end
endmodule

// File: rtl/dq_sigma.sv
module dq_sigma #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step_i,
    input  logic         clear_i,
    input  logic [W-1:0] frac_i,
    output logic         up_o
);
    logic [W-1:0] acc_q;
    logic [W-1:0] acc_eff;
    logic [W:0]   sum;

    assign acc_eff = clear_i ? '0 : acc_q;
    assign sum     = {1'b0, acc_eff} + {1'b0, frac_i};
    assign up_o    = sum[W];

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else if (step_i)
            acc_q <= sum[W-1:0];
    end
endmodule

// File: rtl/dither_quantizer.sv
module dither_quantizer
    import dq_pkg::*;
#(
    parameter int                CMD_W     = 16,
    parameter int                OUT_W     = 8,
    parameter int                PH_W      = 2,
    parameter int                LFSR_W    = 16,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CMD_W-1:0] cmd_i,
    input  logic [1:0]       mode_i,
    input  logic             period_i,
    output logic [OUT_W-1:0] duty_o,
    output logic             valid_o
);
    localparam int FRAC_W = CMD_W - OUT_W;

    logic [OUT_W-1:0]  base;
    logic [OUT_W-1:0]  upper;
    logic [FRAC_W-1:0] frac;
    dq_mode_e          mode_sel;
    dq_mode_e          mode_q;
    logic              mode_switch;
    dq_votes_t         votes;
    logic              up_sel;

    assign base        = cmd_i[CMD_W-1:FRAC_W];
    assign frac        = cmd_i[FRAC_W-1:0];
    assign mode_sel    = dq_mode_e'(mode_i);
    assign mode_switch = (mode_sel != mode_q);
    assign upper       = (&base) ? base : base + OUT_W'(1);

    dq_pattern_seq #(.PH_W(PH_W)) u_pat (
        .clk     (clk),
        .rst     (rst),
        .step_i  (period_i),
        .clear_i (mode_switch),
        .k_i     (frac[FRAC_W-1 -: PH_W]),
        .up_o    (votes.pat)
    );

    dq_lfsr #(
        .W     (LFSR_W),
        .CMP_W (FRAC_W),
        .TAPS  (LFSR_TAPS),
        .SEED  (LFSR_SEED)
    ) u_rnd (
        .clk    (clk),
        .rst    (rst),
        .step_i (period_i),
        .frac_i (frac),
        .up_o   (votes.rnd)
    );

    dq_sigma #(.W(FRAC_W)) u_sd (
        .clk     (clk),
        .rst     (rst),
        .step_i  (period_i),
        .clear_i (mode_switch),
        .frac_i  (frac),
        .up_o    (votes.sd)
    );

    assign up_sel = dq_pick(mode_sel, votes);

    always_ff @(posedge clk) begin
        if (rst) begin
            duty_o  <= '0;
            valid_o <= 1'b0;
            mode_q  <= DQ_PATTERN;
        end else begin
            valid_o <= period_i;
            if (period_i) begin
                duty_o <= up_sel ? upper : base;
                mode_q <= mode_sel;
            end
        end
    end
endmodule

// File: rtl/dq_checker.sv
module dq_checker #(
    parameter int CMD_W = 16,
    parameter int OUT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [CMD_W-1:0] cmd_i,
    input logic             period_i,
    input logic [OUT_W-1:0] duty_o,
    input logic             valid_o
);
    localparam int FRAC_W = CMD_W - OUT_W;

    logic [OUT_W-1:0]  int_part;
    logic [FRAC_W-1:0] frac_part;
    assign int_part  = cmd_i[CMD_W-1:FRAC_W];
    assign frac_part = cmd_i[FRAC_W-1:0];

    // R1
    adjacent_level_chk: assert property (@(posedge clk) disable iff (rst)
        period_i |=> (duty_o == $past(int_part)) || (duty_o == $past(int_part) + OUT_W'(1)));

    // R2
    zero_frac_chk: assert property (@(posedge clk) disable iff (rst)
        (period_i && frac_part == '0) |=> duty_o == $past(int_part));

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (period_i && (&int_part)) |=> (&duty_o));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !period_i |=> ($stable(duty_o) && !valid_o));

    // R4
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        period_i |=> valid_o);
endmodule

bind dither_quantizer dq_checker #(.CMD_W(CMD_W), .OUT_W(OUT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cmd_i    (cmd_i),
    .period_i (period_i),
    .duty_o   (duty_o),
    .valid_o  (valid_o)
);

// File: tb/dither_quantizer_test.sv
module dither_quantizer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cmd_i = '0;
    logic [1:0]  mode_i = '0;
    logic        period_i = 1'b0;
    logic [7:0]  duty_o;
    logic        valid_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    int          m_ph, m_ac, m_last;
    logic [15:0] m_lf;

    always #2 clk = ~clk;

    dither_quantizer uut (
        .clk(clk), .rst(rst), .cmd_i(cmd_i), .mode_i(mode_i),
        .period_i(period_i), .duty_o(duty_o), .valid_o(valid_o)
    );

    // {mode, cmd, strobe count}
    localparam int NV = 11;
    localparam logic [25:0] VEC [NV] = '{
        {2'd0, 16'h4040, 8'd8},
        {2'd0, 16'h1080, 8'd8},
        {2'd0, 16'h33C0, 8'd8},
        {2'd1, 16'h8080, 8'd20},
        {2'd1, 16'h2013, 8'd20},
        {2'd2, 16'h5540, 8'd16},
        {2'd2, 16'h07FF, 8'd16},
        {2'd3, 16'h9001, 8'd8},
        {2'd0, 16'hFFC0, 8'd8},
        {2'd1, 16'hFFFF, 8'd8},
        {2'd0, 16'h1200, 8'd4}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ph = 0; m_ac = 0; m_last = 0; m_lf = 16'hACE1;
    endtask

    task automatic model_step(input int mode, input logic [15:0] cmd, output int exp);
        int  base, fr, k;
        bit  up;
        logic lsb;
        base = int'(cmd[15:8]);
        fr   = int'(cmd[7:0]);
        k    = fr / 64;
        if (mode != m_last) begin m_ph = 0; m_ac = 0; end
        if (mode == 0)      up = (m_ph + k) >= 4;
        else if (mode == 1) up = fr > int'(m_lf[15:8]);
        else                up = (m_ac + fr) >= 256;
        m_ph = (m_ph + 1) % 4;
        m_ac = (m_ac + fr) % 256;
        lsb  = m_lf[0];
        m_lf = {1'b0, m_lf[15:1]};
        if (lsb) m_lf = m_lf ^ 16'hB400;
        m_last = mode;
        exp = up ? ((base == 255) ? 255 : base + 1) : base;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; period_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    // one strobe; samples at the negedge after the registering edge
    task automatic strobe(input int mode, input logic [15:0] cmd, input string tag, output int got);
        int exp;
        @(negedge clk);
        mode_i = 2'(mode); cmd_i = cmd; period_i = 1'b1;
        model_step(mode, cmd, exp);
        @(negedge clk);
        period_i = 1'b0;
        got = int'(duty_o);
        check(duty_o == 8'(exp), tag, got, exp);
        check(valid_o == 1'b1, "R4 valid pulse", int'(valid_o), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int got;
        int ups;
        int seq [6];
        do_reset();
        // R10 reset state
        check(duty_o == 8'h00, "R10 duty after reset", int'(duty_o), 0);
        check(valid_o == 1'b0, "R10 valid after reset", int'(valid_o), 0);

        // R5 explicit fixed-cycle order for k=1
        for (int i = 0; i < 4; i++) begin
            strobe(0, 16'h3040, "R5 pattern k=1", got);
            check(got == ((i == 3) ? 8'h31 : 8'h30), "R5 order", got, (i == 3) ? 8'h31 : 8'h30);
        end

        // R4 hold between strobes, even with a changing command
        cmd_i = 16'hA0FF;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(duty_o == 8'h31, "R4 hold", int'(duty_o), 8'h31);
            check(valid_o == 1'b0, "R4 valid low", int'(valid_o), 0);
        end

        // table walk against the reference model
        for (int v = 0; v < NV; v++) begin
            int    md;
            string tg;
            md = int'(VEC[v][25:24]);
            tg = (md == 0) ? "R5 table" : (md == 1) ? "R6 table" : "R7 table";
            for (int n = 0; n < int'(VEC[v][7:0]); n++) begin
                strobe(md, VEC[v][23:8], tg, got);
                check(got == int'(VEC[v][23:16]) || got == int'(VEC[v][23:16]) + 1,
                      "R1 adjacent", got, int'(VEC[v][23:16]));
            end
        end

        // R3 saturation in error-feedback mode
        for (int i = 0; i < 4; i++) begin
            strobe(2, 16'hFFFF, "R3 saturate", got);
            check(got == 8'hFF, "R3 max code", got, 8'hFF);
        end

        // R2 zero fraction in every mode
        for (int m = 0; m < 4; m++) begin
            strobe(m, 16'h6600, "R2 zero frac", got);
            check(got == 8'h66, "R2 floor", got, 8'h66);
        end

        // R9 mode switch clears residues
        strobe(2, 16'h40C0, "R9 prime", got);
        strobe(2, 16'h40C0, "R9 prime", got);
        strobe(0, 16'h40C0, "R9 pattern after switch", got);
        check(got == 8'h40, "R9 phase cleared", got, 8'h40);
        strobe(2, 16'h40C0, "R9 sigma after switch", got);
        check(got == 8'h40, "R9 accumulator cleared", got, 8'h40);

        // R8 average over 256 periods
        strobe(0, 16'h2000, "R8 setup", got);
        ups = 0;
        for (int i = 0; i < 256; i++) begin
            strobe(2, 16'h205B, "R8 step", got);
            if (got == 8'h21) ups++;
        end
        check(ups == 8'h5B, "R8 upper count", ups, 8'h5B);

        // R10 reset reseeds the random sequence
        do_reset();
        for (int i = 0; i < 6; i++) strobe(1, 16'h7080, "R6 after reset", seq[i]);
        do_reset();
        for (int i = 0; i < 6; i++) begin
            strobe(1, 16'h7080, "R6 repeat", got);
            check(got == seq[i], "R10 reseed repeat", got, seq[i]);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule